// File: doc/BRIEF.md
# Multi-Domain Memory Bounds Checker

This block sits beside a processor's load, store and fetch path and decides, in the same cycle, whether an access may go ahead. It holds a small bank of domain registers. Each register gives an inclusive address window, read, write and execute permission bits, a kernel-only flag and a valid flag. Every access is compared against all of the registers in parallel. The block reports one of three outcomes: the access is granted, the address falls outside every usable window (an illegal reference), or the address is inside at least one window but no window allows this type of access (a permission fault).

The domain registers are loaded through a single write port. A write lands only while the processor is in supervisor mode. A write attempted from user mode changes nothing and raises an illegal-operation flag in the same cycle. The check itself has no registers: the three outcome outputs follow the access inputs and the current register contents combinationally.

Top module: `mem_domain_guard`

## Requirements
- R1: After reset every domain register is invalid, so any access raises the illegal-reference fault until supervisor software loads a domain.
- R2: A valid domain matches an address when low <= address <= high. Both bounds are inside the domain. The addresses one below low and one above high are outside it.
- R3: A valid domain whose low bound is greater than its high bound matches no address.
- R4: When `acc_valid` is 1 and no valid domain matches, `fault_bounds` is 1 and `acc_grant` and `fault_perm` are 0.
- R5: Access type encoding on `acc_kind`: 0 is a read and needs attribute bit 0, 1 is a write and needs bit 1, 2 is a fetch and needs bit 2. Code 3 is never permitted by any domain.
- R6: When at least one domain matches and none of the matching domains allows the access, `fault_perm` is 1 and `acc_grant` and `fault_bounds` are 0.
- R7: When several domains match, the access is granted if any one of them allows it.
- R8: A domain with attribute bit 3 (kernel-only) set allows nothing while `priv_sup` is 0, but it still counts as a match. While `priv_sup` is 1 it allows access according to bits 0 to 2.
- R9: With `cfg_we` = 1 and `priv_sup` = 1, register `cfg_sel` takes `cfg_lo`, `cfg_hi` and `cfg_attr` at the clock edge. In `cfg_attr`, bit 4 is valid, bit 3 is kernel-only, bit 2 is execute, bit 1 is write and bit 0 is read. The new contents govern accesses from the next cycle.
- R10: With `cfg_we` = 1 and `priv_sup` = 0, `cfg_illegal` is 1 in that cycle and no domain register changes.
- R11: When `acc_valid` is 0, `acc_grant`, `fault_bounds` and `fault_perm` are all 0.
- R12: When `acc_valid` is 1, exactly one of `acc_grant`, `fault_bounds` and `fault_perm` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| priv_sup | input | 1 | 1 when the processor is in supervisor mode |
| cfg_we | input | 1 | Domain register write request |
| cfg_sel | input | IDX_W | Domain register index |
| cfg_lo | input | ADDR_W | Low bound to write |
| cfg_hi | input | ADDR_W | High bound to write |
| cfg_attr | input | 5 | {valid, kernel-only, execute, write, read} |
| acc_grant | output | 1 | Access may proceed |
| fault_bounds | output | 1 | Illegal-reference fault |
| fault_perm | output | 1 | Permission fault |
| cfg_illegal | output | 1 | Register write attempted from user mode |

## Verification
The bench targets the bound edges: addresses exactly at low and high, and one past each side. A design that used strict comparisons would fault on the edges, and one that was off by one would grant an address outside the window. It overlaps a read/write domain, an execute-only domain and a kernel-only domain. A design that picked only the first match would raise permission faults where another domain grants the access, and a design that skipped kernel-only domains would report illegal references where a permission fault is due. It also covers an inverted window, the reserved access code, the idle cycle, and a user-mode register write whose effect is probed afterward through a supervisor access. A design that let that write land would grant an address that should stay unmapped.

// File: rtl/dg_pkg.sv
package dg_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   // Attribute word: bit 4 valid, 3 kernel-only, 2 execute, 1 write, 0 read
   typedef struct packed {
      logic valid;
      logic kern;
      logic x;
      logic w;
      logic r;
   } dom_attr_t;

   localparam int ATTR_W = $bits(dom_attr_t);

endpackage

// File: rtl/dg_regfile.sv
module dg_regfile
   import dg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_DOM = 4,
   parameter int IDX_W   = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic                           cfg_sup,
   input  logic [IDX_W-1:0]               cfg_sel,
   input  logic [ADDR_W-1:0]              cfg_lo,
   input  logic [ADDR_W-1:0]              cfg_hi,
   input  dom_attr_t                      cfg_attr,
   output logic [NUM_DOM-1:0][ADDR_W-1:0] lo_q,
   output logic [NUM_DOM-1:0][ADDR_W-1:0] hi_q,
   output dom_attr_t [NUM_DOM-1:0]        attr_q,
   output logic                           cfg_illegal
);

   logic wr_ok;
   assign wr_ok       = cfg_we & cfg_sup;
   assign cfg_illegal = cfg_we & ~cfg_sup;

   for (genvar i = 0; i < NUM_DOM; i++) begin : g_ent
      logic hit_sel;
      assign hit_sel = wr_ok && (cfg_sel == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[i]   <= '0;
            hi_q[i]   <= '0;
            attr_q[i] <= '0;
         end else if (hit_sel) begin
            lo_q[i]   <= cfg_lo;
            hi_q[i]   <= cfg_hi;
            attr_q[i] <= cfg_attr;
         end
      end

      assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_sup && cfg_sel == IDX_W'(i)) |=>
            (lo_q[i] == $past(cfg_lo) && hi_q[i] == $past(cfg_hi) &&
             attr_q[i] == $past(cfg_attr)));
   end

   assert_user_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sup) |=> ($stable(lo_q) && $stable(hi_q) && $stable(attr_q)));

   logic [NUM_DOM-1:0] valid_vec;
   always_comb begin
      for (int k = 0; k < NUM_DOM; k++) valid_vec[k] = attr_q[k].valid;
   end

   assert_reset_invalid_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (valid_vec == '0));

endmodule

// File: rtl/dg_match.sv
module dg_match
   import dg_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_kind_e         kind,
   input  logic              sup,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  dom_attr_t         attr,
   output logic              hit,
   output logic              allow
);

   logic type_ok;

   always_comb begin
      unique case (kind)
         ACC_READ:  type_ok = attr.r;
         ACC_WRITE: type_ok = attr.w;
         ACC_FETCH: type_ok = attr.x;
         default:   type_ok = 1'b0;
      endcase
   end

   // Inclusive window; an inverted window can satisfy neither side together
   assign hit   = attr.valid && (addr >= lo) && (addr <= hi);
   assign allow = hit && type_ok && (sup || !attr.kern);

endmodule

// File: rtl/dg_resolve.sv
module dg_resolve #(
   parameter int NUM_DOM = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [NUM_DOM-1:0] hit_vec,
   input  logic [NUM_DOM-1:0] allow_vec,
   output logic               grant,
   output logic               f_bounds,
   output logic               f_perm
);

   logic any_hit, any_allow;
   assign any_hit   = |hit_vec;
   assign any_allow = |allow_vec;

   assign grant    = acc_valid & any_allow;
   assign f_bounds = acc_valid & ~any_hit;
   assign f_perm   = acc_valid & any_hit & ~any_allow;

   assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ($countones({grant, f_bounds, f_perm}) == 1));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(grant || f_bounds || f_perm));

   assert_bounds_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      f_bounds |-> (hit_vec == '0));

   assert_perm_has_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      f_perm |-> (hit_vec != '0 && allow_vec == '0));

   assert_grant_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && allow_vec != '0) |-> grant);

endmodule

// File: rtl/mem_domain_guard.sv
module mem_domain_guard
   import dg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_DOM = 4,
   localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_kind,
   input  logic              priv_sup,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_lo,
   input  logic [ADDR_W-1:0] cfg_hi,
   input  logic [4:0]        cfg_attr,
   output logic              acc_grant,
   output logic              fault_bounds,
   output logic              fault_perm,
   output logic              cfg_illegal
);

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
      $error("mem_domain_guard: ADDR_W out of range");
   end
   if (NUM_DOM < 1 || NUM_DOM > 64) begin : g_bad_dom
      $error("mem_domain_guard: NUM_DOM out of range");
   end

   logic [NUM_DOM-1:0][ADDR_W-1:0] lo_q, hi_q;
   dom_attr_t [NUM_DOM-1:0]        attr_q;
   logic [NUM_DOM-1:0]             hit_vec, allow_vec;
   acc_kind_e                      kind;

   assign kind = acc_kind_e'(acc_kind);

   dg_regfile #(
      .ADDR_W (ADDR_W),
      .NUM_DOM(NUM_DOM),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sup    (priv_sup),
      .cfg_sel    (cfg_sel),
      .cfg_lo     (cfg_lo),
      .cfg_hi     (cfg_hi),
      .cfg_attr   (dom_attr_t'(cfg_attr)),
      .lo_q       (lo_q),
      .hi_q       (hi_q),
      .attr_q     (attr_q),
      .cfg_illegal(cfg_illegal)
   );

   for (genvar i = 0; i < NUM_DOM; i++) begin : g_cmp
      dg_match #(.ADDR_W(ADDR_W)) u_match (
         .addr (acc_addr),
         .kind (kind),
         .sup  (priv_sup),
         .lo   (lo_q[i]),
         .hi   (hi_q[i]),
         .attr (attr_q[i]),
         .hit  (hit_vec[i]),
         .allow(allow_vec[i])
      );
   end

   dg_resolve #(.NUM_DOM(NUM_DOM)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_valid(acc_valid),
      .hit_vec  (hit_vec),
      .allow_vec(allow_vec),
      .grant    (acc_grant),
      .f_bounds (fault_bounds),
      .f_perm   (fault_perm)
   );

   assert_kernel_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !priv_sup && (allow_vec & hit_vec) == '0 && hit_vec != '0) |-> !acc_grant);

endmodule

// File: tb/mem_domain_guard_test.sv
module mem_domain_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        priv_sup = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_lo = '0;
   logic [31:0] cfg_hi = '0;
   logic [4:0]  cfg_attr = '0;
   logic        acc_grant, fault_bounds, fault_perm, cfg_illegal;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   mem_domain_guard uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .priv_sup(priv_sup), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_attr(cfg_attr), .acc_grant(acc_grant),
      .fault_bounds(fault_bounds), .fault_perm(fault_perm), .cfg_illegal(cfg_illegal)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  kind;
      logic        sup;
      logic [2:0]  exp;   // {grant, bounds, perm}
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 2'd0, 1'b0, 3'b100, 4'd2},  // R2 low edge
      '{32'h0000_0FFF, 2'd0, 1'b0, 3'b010, 4'd2},  // R2 below low
      '{32'h0000_1FFF, 2'd1, 1'b0, 3'b100, 4'd2},  // R2 high edge
      '{32'h0000_1000, 2'd2, 1'b0, 3'b001, 4'd6},  // R6 no exec
      '{32'h0000_1800, 2'd2, 1'b0, 3'b100, 4'd7},  // R7 via exec-only domain
      '{32'h0000_1800, 2'd1, 1'b0, 3'b100, 4'd7},  // R7 via rw domain
      '{32'h0000_2000, 2'd0, 1'b0, 3'b001, 4'd8},  // R8 kernel domain, user
      '{32'h0000_2000, 2'd0, 1'b1, 3'b100, 4'd8},  // R8 kernel domain, sup
      '{32'h0000_2800, 2'd0, 1'b1, 3'b100, 4'd5},  // R5 read allowed
      '{32'h0000_2800, 2'd1, 1'b1, 3'b001, 4'd5},  // R5 write not allowed
      '{32'h0000_2800, 2'd2, 1'b0, 3'b001, 4'd8},  // R8 user fetch kernel
      '{32'h0000_8800, 2'd0, 1'b1, 3'b010, 4'd3},  // R3 inverted window
      '{32'h0000_9000, 2'd0, 1'b1, 3'b010, 4'd3},  // R3 at its low value
      '{32'h0000_1000, 2'd3, 1'b1, 3'b001, 4'd5},  // R5 reserved code
      '{32'hFFFF_FFFF, 2'd0, 1'b1, 3'b010, 4'd4},  // R4 top of space
      '{32'h0000_3000, 2'd2, 1'b1, 3'b010, 4'd4}   // R4 gap
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_dom(input logic sup, input logic [1:0] sel,
                         input logic [31:0] lo, input logic [31:0] hi, input logic [4:0] at);
      @(negedge clk);
      priv_sup = sup; cfg_we = 1'b1; cfg_sel = sel;
      cfg_lo = lo; cfg_hi = hi; cfg_attr = at;
      #1;
      if (!sup) check("R10 illegal flag", {31'd0, cfg_illegal}, 32'd1);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic s);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_kind = k; priv_sup = s;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: nothing mapped after reset
      probe(32'h0000_1000, 2'd0, 1'b1);
      check("R1 reset outcome", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b010);
      check("R1 no illegal", {31'd0, cfg_illegal}, 32'd0);

      // R11: idle access
      @(negedge clk); acc_valid = 1'b0; #1;
      check("R11 idle", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b000);

      // R9: supervisor loads the domains
      wr_dom(1'b1, 2'd0, 32'h0000_1000, 32'h0000_1FFF, 5'b10011);
      wr_dom(1'b1, 2'd1, 32'h0000_2000, 32'h0000_2FFF, 5'b11101);
      wr_dom(1'b1, 2'd2, 32'h0000_1800, 32'h0000_27FF, 5'b10100);
      wr_dom(1'b1, 2'd3, 32'h0000_9000, 32'h0000_8000, 5'b10111);

      for (int i = 0; i < NV; i++) begin
         probe(VECS[i].addr, VECS[i].kind, VECS[i].sup);
         check($sformatf("R%0d vector %0d", VECS[i].req, i),
               {29'd0, acc_grant, fault_bounds, fault_perm}, {29'd0, VECS[i].exp});
         check($sformatf("R12 vector %0d", i),
               $countones({acc_grant, fault_bounds, fault_perm}), 32'd1);
      end

      // R10: user write to domain 3 must not land
      @(negedge clk); acc_valid = 1'b0;
      wr_dom(1'b0, 2'd3, 32'h0000_5000, 32'h0000_5FFF, 5'b10111);
      probe(32'h0000_5000, 2'd0, 1'b1);
      check("R10 write ignored", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b010);
      probe(32'h0000_8800, 2'd0, 1'b1);
      check("R10 old entry kept", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b010);

      // R9: same write from supervisor lands
      @(negedge clk); acc_valid = 1'b0;
      wr_dom(1'b1, 2'd3, 32'h0000_5000, 32'h0000_5FFF, 5'b10111);
      check("R9 no illegal flag", {31'd0, cfg_illegal}, 32'd0);
      probe(32'h0000_5000, 2'd1, 1'b0);
      check("R9 write lands", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b100);
      probe(32'h0000_6000, 2'd1, 1'b0);
      check("R2 past new high", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b010);

      // R1: a fresh reset clears all domains again
      @(negedge clk); acc_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      probe(32'h0000_5000, 2'd0, 1'b1);
      check("R1 cleared by reset", {29'd0, acc_grant, fault_bounds, fault_perm}, 32'b010);

      @(negedge clk); acc_valid = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule